// File: doc/BRIEF.md
# Time/Date Shadow Snapshot Buffer

This block sits between a free-running BCD time-of-day and calendar counter and a serial register-access front end. A host reading time and date always receives a coherent picture. All seven registers are copied together into a shadow bank, and reads are served from that copy while the live counter keeps advancing underneath. The copy is refreshed when the front end reports a bus start. It is also refreshed when the auto-incrementing register pointer rolls from the last address back to zero.

Host writes go to the live counter in the cycle the front end signals the byte acknowledge. A write to the seconds register also clears the sub-second prescaler, so the next whole-second step comes one full second after the write. The live counter carries seconds into minutes, then hours (24-hour), date, month and year. It also steps a day-of-week register at midnight. February gets 29 days in years that are a multiple of four.

Register map (pointer value, packed BCD): 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year.

Top module: `rtc_shadow_bank`

## Requirements
- R1: After reset the live registers read 00:00:00, day-of-week 1, date 01, month 01, year 00. The shadow bank holds the same values, the pointer is 0 and `rd_data` is 00h.
- R2: A cycle with `bus_start` high copies all seven live registers, as they stood before that edge, into the shadow bank.
- R3: A `rd_ack` or `wr_ack` while the pointer is 6 and `ptr_load` is low returns the pointer to 0. It also refreshes the shadow bank exactly as R2 does.
- R4: `rd_data` shows, one cycle later, the shadow byte addressed by the pointer in the previous cycle. The shadow bank changes only on R2 or R3 events, even while the live counter advances.
- R5: A write to address 0 clears the prescaler and suppresses any second step in that cycle. The seconds register then changes only after SUB_PER_SEC further `sub_tick` cycles.
- R6: On `wr_ack` the byte `wr_data` is stored into the live register at the current pointer, and the pointer advances by one. `ptr_load` sets the pointer to `ptr_in`, and a value above 6 loads 0.
- R7: When a second step and a host write coincide, the written register takes `wr_data` and not the stepped value. The other registers still step.
- R8: Each second step counts seconds and minutes 00–59 and hours 00–23 in BCD, with a carry into the next field at each wrap. Date carries into month (01–12) and month into year (00–99).
- R9: Day-of-week advances by one when the hours wrap from 23 to 00, and goes from 7 back to 1.
- R10: Date wraps after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. Month 02 wraps after 29 when the year is a multiple of four and after 28 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Sub-second prescaler enable, SUB_PER_SEC per second |
| bus_start | input | 1 | Bus start condition seen (one-cycle strobe) |
| ptr_load | input | 1 | Load the register pointer from `ptr_in` |
| ptr_in | input | 3 | New pointer value |
| rd_ack | input | 1 | Read byte acknowledged; pointer advances |
| wr_ack | input | 1 | Write byte acknowledged; commit `wr_data` and advance |
| wr_data | input | 8 | Host write byte (BCD) |
| rd_data | output | 8 | Shadow byte at the pointer (registered) |
| live_time | output | 56 | Live registers, byte n = address n |

## Verification
The hardest situation to reach is a second step landing in the same cycle as a host write to a register that the step would change. The stimulus builds it on purpose. A seconds write of 59 clears the prescaler, and the bench then waits exactly SUB_PER_SEC-1 cycles with `sub_tick` high. The minutes write then lands on the step edge. Shadow coherence is exercised by holding a read burst open across several live seconds and a midnight rollover. The burst ends by acking through address 6, so that the wrap refresh is observed in the next byte read.

// File: rtl/rtc_shadow_pkg.sv
`timescale 1ns/1ps
package rtc_shadow_pkg;

  localparam int NREG  = 7;
  localparam int PTR_W = 3;
  localparam int LAST  = NREG - 1;

  // Byte n of the packed value is register address n (seconds in the low byte).
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                     dow: 8'h01, hrs: 8'h00, mins: 8'h00,
                                     sec: 8'h00};

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] n);
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    return bin2bcd(bcd2bin(b) + 7'd1);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
    logic [6:0] y;
    y = bcd2bin(year);
    case (mon)
      8'h02:                      return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // One whole-second step of the calendar.
  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.mins != 8'h59) n.mins = bcd_inc(t.mins);
      else begin
        n.mins = 8'h00;
        if (t.hrs != 8'h23) n.hrs = bcd_inc(t.hrs);
        else begin
          n.hrs = 8'h00;
          n.dow = (t.dow >= 8'h07) ? 8'h01 : t.dow + 8'h01;
          if (t.date != last_day(t.mon, t.year)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
            else begin
              n.mon  = 8'h01;
              n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int SUB_PER_SEC = 32768,
  localparam int CNT_W = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sub_tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sec_tick
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(SUB_PER_SEC - 1);

  assign sec_tick = sub_tick && (cnt_q == TOP) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt_q <= '0;
    else if (sub_tick) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rtc_live_counter.sv
`timescale 1ns/1ps
module rtc_live_counter
  import rtc_shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_tick,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output rtc_time_t        live_q
);
  rtc_time_t nxt;

  always_comb begin
    nxt = sec_tick ? advance(live_q) : live_q;
    if (wr_en) nxt[{wr_idx, 3'b000} +: 8] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= TIME_RST;
    else     live_q <= nxt;
  end
endmodule

// File: rtl/rtc_shadow_regs.sv
`timescale 1ns/1ps
module rtc_shadow_regs
  import rtc_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  rtc_time_t         live_q,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [NREG*8-1:0] snap_q,
  output logic [7:0]        rd_data
);
  logic [7:0] shadow_q [NREG];
  logic       wrap;
  logic       capture;

  assign wrap    = step && !ptr_load && (ptr_q == PTR_W'(LAST));
  assign capture = bus_start || wrap;

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)          shadow_q[g] <= TIME_RST[g*8 +: 8];
      else if (capture) shadow_q[g] <= live_q[g*8 +: 8];
    end
    assign snap_q[g*8 +: 8] = shadow_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= shadow_q[ptr_q];
      if (ptr_load)  ptr_q <= (ptr_in > PTR_W'(LAST)) ? '0 : ptr_in;
      else if (step) ptr_q <= wrap ? '0 : ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/rtc_shadow_bank.sv
`timescale 1ns/1ps
module rtc_shadow_bank
  import rtc_shadow_pkg::*;
#(
  parameter int SUB_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_tick,
  input  logic              bus_start,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic              rd_ack,
  input  logic              wr_ack,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] live_time
);
  localparam int CNT_W = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;

  logic [CNT_W-1:0]  presc_cnt;
  logic              sec_tick;
  logic              sec_wr;
  logic [PTR_W-1:0]  ptr_q;
  logic [NREG*8-1:0] snap_q;
  rtc_time_t         live_q;

  assign sec_wr    = wr_ack && (ptr_q == '0);
  assign live_time = live_q;

  rtc_prescaler #(.SUB_PER_SEC(SUB_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .sub_tick(sub_tick), .clr(sec_wr),
    .cnt_q(presc_cnt), .sec_tick(sec_tick)
  );

  rtc_live_counter u_live (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_ack),
    .wr_idx(ptr_q), .wr_data(wr_data), .live_q(live_q)
  );

  rtc_shadow_regs u_shadow (
    .clk(clk), .rst(rst), .bus_start(bus_start), .live_q(live_q),
    .ptr_load(ptr_load), .ptr_in(ptr_in), .step(rd_ack || wr_ack),
    .ptr_q(ptr_q), .snap_q(snap_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/rtc_shadow_chk.sv
`timescale 1ns/1ps
module rtc_shadow_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_start,
  input logic        ptr_load,
  input logic        rd_ack,
  input logic        wr_ack,
  input logic [7:0]  wr_data,
  input logic [2:0]  ptr_q,
  input logic [55:0] snap_q,
  input logic [55:0] live_time,
  input logic [31:0] presc_cnt
);
  logic wrap_ev;
  assign wrap_ev = (rd_ack || wr_ack) && !ptr_load && (ptr_q == 3'd6);

  // R2
  start_snap_chk: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> snap_q == $past(live_time));

  // R3
  wrap_snap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_ev |=> (snap_q == $past(live_time)) && (ptr_q == 3'd0));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_start && !wrap_ev) |=> $stable(snap_q));

  // R5
  sec_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && ptr_q == 3'd0) |=> presc_cnt == 32'd0);

  // R6
  wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> live_time[8*$past(ptr_q) +: 8] == $past(wr_data));
endmodule

bind rtc_shadow_bank rtc_shadow_chk u_rtc_shadow_chk (
  .clk(clk), .rst(rst), .bus_start(bus_start), .ptr_load(ptr_load),
  .rd_ack(rd_ack), .wr_ack(wr_ack), .wr_data(wr_data), .ptr_q(ptr_q),
  .snap_q(snap_q), .live_time(live_time), .presc_cnt(32'(presc_cnt))
);

// File: tb/test_rtc_shadow_bank.sv
`timescale 1ns/1ps
module test_rtc_shadow_bank;
  localparam int SUB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sub_tick = 1'b0, bus_start = 1'b0, ptr_load = 1'b0;
  logic [2:0]  ptr_in = '0;
  logic        rd_ack = 1'b0, wr_ack = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [55:0] live_time;

  int    n_checks = 0, n_errors = 0;
  bit    armed = 0;
  string phase = "R1";

  rtc_shadow_bank #(.SUB_PER_SEC(SUB)) i_rtc_shadow_bank (
    .clk(clk), .rst(rst), .sub_tick(sub_tick), .bus_start(bus_start),
    .ptr_load(ptr_load), .ptr_in(ptr_in), .rd_ack(rd_ack), .wr_ack(wr_ack),
    .wr_data(wr_data), .rd_data(rd_data), .live_time(live_time)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model (decimal integers) ----------------
  int m_t[7], m_snap[7];
  int m_presc, m_ptr, m_rd;

  function automatic int to_int(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int month_len(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_second();
    m_t[0]++;
    if (m_t[0] < 60) return;
    m_t[0] = 0; m_t[1]++;
    if (m_t[1] < 60) return;
    m_t[1] = 0; m_t[2]++;
    if (m_t[2] < 24) return;
    m_t[2] = 0;
    m_t[3] = (m_t[3] == 7) ? 1 : m_t[3] + 1;
    m_t[4]++;
    if (m_t[4] <= month_len(m_t[5], m_t[6])) return;
    m_t[4] = 1; m_t[5]++;
    if (m_t[5] <= 12) return;
    m_t[5] = 1; m_t[6] = (m_t[6] + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_t = '{0, 0, 0, 1, 1, 1, 0};
      m_snap = m_t;
      m_presc = 0; m_ptr = 0; m_rd = 0;
    end else begin
      bit sec_wr, tick, step;
      sec_wr = wr_ack && m_ptr == 0;
      tick   = sub_tick && m_presc == SUB - 1 && !sec_wr;
      step   = rd_ack || wr_ack;
      if (sec_wr) m_presc = 0;
      else if (sub_tick) m_presc = (m_presc == SUB - 1) ? 0 : m_presc + 1;
      m_rd = m_snap[m_ptr];
      if (bus_start || (step && !ptr_load && m_ptr == 6)) m_snap = m_t;
      if (tick) model_second();
      if (wr_ack) m_t[m_ptr] = to_int(wr_data);
      if (ptr_load) m_ptr = (ptr_in > 6) ? 0 : int'(ptr_in);
      else if (step) m_ptr = (m_ptr == 6) ? 0 : m_ptr + 1;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [55:0] model_live();
    logic [55:0] v;
    for (int i = 0; i < 7; i++) v[i*8 +: 8] = to_bcd(m_t[i]);
    return v;
  endfunction

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (armed) begin
      check({phase, " rd_data"}, 64'(rd_data), 64'(to_bcd(m_rd)));
      check({phase, " live"}, 64'(live_time), 64'(model_live()));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] b);
    wr_ack = 1; wr_data = b; cyc(); wr_ack = 0;
  endtask

  task automatic load_ptr(logic [2:0] p);
    ptr_load = 1; ptr_in = p; cyc(); ptr_load = 0;
  endtask

  // Byte order: sec, min, hour, dow, date, month, year.
  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    sub_tick = 0;
    load_ptr(0);
    wr_byte(s); wr_byte(mi); wr_byte(h); wr_byte(dw);
    wr_byte(dt); wr_byte(mo); wr_byte(yr);
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [55:0] cap;
    int cnt;
    cyc(3);
    rst = 0;
    cyc();
    armed = 1;
    // R1 reset state
    check("R1 live", 64'(live_time), 64'h00_01_01_01_00_00_00);
    check("R1 rd_data", 64'(rd_data), 64'h0);

    // R6 / R8 carry minutes into hours
    phase = "R8";
    set_time(8'h58, 8'h59, 8'h12, 8'h03, 8'h10, 8'h06, 8'h21);
    check("R6 write", 64'(live_time), 64'h21_06_10_03_12_59_58);
    sub_tick = 1; cyc(2 * SUB); sub_tick = 0;
    check("R8 carry", 64'(live_time), 64'h21_06_10_03_13_00_00);

    // R9 / R10 leap February, dow 7 -> 1
    phase = "R10";
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
    sub_tick = 1; cyc(SUB); sub_tick = 0;
    check("R10 leap feb", 64'(live_time), 64'h24_02_29_01_00_00_00);
    check("R9 dow wrap", 64'(live_time[31:24]), 64'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h23);
    sub_tick = 1; cyc(SUB); sub_tick = 0;
    check("R10 common feb", 64'(live_time), 64'h23_03_01_05_00_00_00);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23);
    sub_tick = 1; cyc(SUB); sub_tick = 0;
    check("R10 30-day", 64'(live_time), 64'h23_05_01_03_00_00_00);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    sub_tick = 1; cyc(SUB); sub_tick = 0;
    check("R8 year wrap", 64'(live_time), 64'h00_01_01_07_00_00_00);

    // R5 seconds write restarts the sub-second chain
    phase = "R5";
    sub_tick = 1; cyc(3);
    load_ptr(0);
    wr_byte(8'h10);
    cnt = 0;
    while (live_time[7:0] == 8'h10 && cnt < 20) begin cyc(); cnt++; end
    check("R5 full second", 64'(cnt), 64'(SUB));

    // R7 write and second step in the same cycle
    phase = "R7";
    sub_tick = 0;
    set_time(8'h00, 8'h05, 8'h10, 8'h02, 8'h15, 8'h07, 8'h22);
    load_ptr(0);
    sub_tick = 1;
    wr_byte(8'h59);          // presc cleared
    cyc(SUB - 1);            // presc reaches SUB-1
    wr_byte(8'h40);          // minutes write lands on the step edge
    sub_tick = 0;
    check("R7 written reg", 64'(live_time[15:8]), 64'h40);
    check("R7 other reg", 64'(live_time[7:0]), 64'h00);

    // R2 / R4 coherent burst across running time
    phase = "R4";
    set_time(8'h57, 8'h59, 8'h23, 8'h03, 8'h09, 8'h09, 8'h30);
    load_ptr(0);
    cap = live_time;
    bus_start = 1; cyc(); bus_start = 0;
    sub_tick = 1; cyc(4 * SUB);
    for (int i = 0; i < 7; i++) begin
      if (i == 6) cap[55:48] = cap[55:48];
      rd_ack = 1;
      if (i == 6) begin
        // live value before the wrap edge
        logic [55:0] pre;
        pre = live_time;
        cyc(); rd_ack = 0;
        check("R4 byte 6", 64'(rd_data), 64'(cap[55:48]));
        cyc();
        check("R3 wrap refresh", 64'(rd_data), 64'(pre[7:0]));
      end else begin
        cyc(); rd_ack = 0;
        check("R4 shadow byte", 64'(rd_data), 64'(cap[i*8 +: 8]));
        check("R2 live moved", 64'(live_time != cap), 64'h1);
      end
    end
    sub_tick = 0;

    // R6 out-of-range pointer loads 0
    phase = "R6";
    load_ptr(3);
    load_ptr(7);
    cyc();
    check("R6 ptr clamp", 64'(rd_data), 64'(to_bcd(m_snap[0])));

    cyc(2);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule